// File: doc/BRIEF.md
# Serial Receiver Register File with Interrupt Summary

This block is the processor-facing side of a classic asynchronous serial adapter's receive path. A receiver shift stage, outside this block, hands over each assembled byte together with its parity and framing error flags as a one-cycle pulse. The block keeps that byte in a single holding register. It flags overruns, errors and holding-register state in a status register, and raises an active-low interrupt request. It also holds a command register that sets the two modem-control outputs and enables the receive interrupt.

The processor reaches the block through a two-bit register address with read and write strobes. Address 0 reads the held byte. Address 1 reads status, and a write to it clears the latched error flags. Address 2 reads and writes the command register. Address 3 reads zero and ignores writes. The read data is combinational from the selected register. The side effect of a read (clearing a flag) takes place at the clock edge on which the read strobe is high.

There are two small state machines. The holding machine has the states HOLD_EMPTY, HOLD_FULL and HOLD_OVERRUN:
- HOLD_EMPTY goes to HOLD_FULL when a byte arrives.
- HOLD_FULL goes to HOLD_OVERRUN when a byte arrives without a data read. It goes to HOLD_EMPTY on a data read.
- HOLD_OVERRUN goes to HOLD_FULL on an error-clear write or on a data read that coincides with an arrival. It goes to HOLD_EMPTY on a data read alone.

The interrupt machine has the states IRQ_IDLE and IRQ_ASSERTED. It goes from IRQ_IDLE to IRQ_ASSERTED on a set event. It goes from IRQ_ASSERTED back to IRQ_IDLE on a status read that has no set event in the same cycle.

Top module: `acia_rx_regs`

## Requirements
- R1: Status (address 1) bits are: bit 7 interrupt pending, bit 4 transmitter-empty input, bit 3 holding register full, bit 2 overrun, bit 1 framing error, bit 0 parity error. Bits 6 and 5 read zero. Address 3 reads zero.
- R2: A received byte is held and sets status bit 3. A read of address 0 returns the held byte and clears bit 3 at that edge.
- R3: A byte that arrives while the holding register is full, with no data read in that cycle, replaces the held byte and sets status bit 2.
- R4: Parity and framing flags are latched with their byte. The next data read clears them, and so does a write to address 1. The write to address 1 also clears bit 2 but leaves bit 3 and the byte intact.
- R5: Any status read clears bit 7 and drives irq_n high at that edge, even while bit 3 stays set.
- R6: A byte arrival sets bit 7 and drives irq_n low only when command bit 1 is 0.
- R7: A byte that arrives in the same cycle as a status read leaves bit 7 set and irq_n low after that edge.
- R8: A command write with bit 1 at 0, made while bit 3 is set, sets bit 7 and drives irq_n low.
- R9: The command register (address 2) is readable. rts_n is low when command bits 3:2 are nonzero, and dtr_n is low when command bit 0 is 1. For example, 0x09 gives both low, and 0x01 gives rts_n high and dtr_n low.
- R10: A data read in the same cycle as an arrival returns the old byte. The new byte is then held with bit 3 set and bit 2 clear.
- R11: After reset the command register is 0, irq_n, rts_n and dtr_n are high, and status shows only bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 2 | Register select |
| rd_stb | input | 1 | Read strobe, side effects at the clock edge |
| wr_stb | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data of the selected register |
| rx_valid | input | 1 | One-cycle pulse: a byte was assembled |
| rx_byte | input | 8 | Assembled byte |
| rx_par_err | input | 1 | Parity error for rx_byte |
| rx_frm_err | input | 1 | Framing error for rx_byte |
| tx_empty | input | 1 | Transmitter empty, shown in status |
| irq_n | output | 1 | Active-low interrupt request |
| rts_n | output | 1 | Active-low request to send |
| dtr_n | output | 1 | Active-low terminal ready |

## Verification
A wrong holding state appears in status bits 3 and 2 on the first status read after the faulty edge. It also shows as a stale or wrong byte on the next data read. A wrong interrupt state appears on irq_n one cycle after the event, and it matters most at the coincidences: an arrival on a status read, and an arrival on a data read. The bench drives both of these coincidences and samples irq_n on the following cycle. Command decode faults appear directly on rts_n and dtr_n after each command write.

// File: rtl/acia_rx_pkg.sv
package acia_rx_pkg;
    localparam int DW = 8;
    localparam int AW = 2;

    localparam logic [AW-1:0] ADDR_DATA   = 2'd0;
    localparam logic [AW-1:0] ADDR_STATUS = 2'd1;
    localparam logic [AW-1:0] ADDR_CMD    = 2'd2;

    localparam int ST_PAR  = 0;
    localparam int ST_FRM  = 1;
    localparam int ST_OVR  = 2;
    localparam int ST_FULL = 3;
    localparam int ST_TXE  = 4;
    localparam int ST_IRQ  = 7;

    localparam int CMD_DTR    = 0;
    localparam int CMD_RXIDIS = 1;
    localparam int CMD_TXC_LO = 2;
    localparam int CMD_TXC_HI = 3;

    typedef enum logic [1:0] {
        HOLD_EMPTY   = 2'd0,
        HOLD_FULL    = 2'd1,
        HOLD_OVERRUN = 2'd2
    } hold_state_t;

    typedef enum logic {
        IRQ_IDLE     = 1'b0,
        IRQ_ASSERTED = 1'b1
    } irq_state_t;
endpackage

// File: rtl/acia_rx_hold.sv
module acia_rx_hold
    import acia_rx_pkg::*;
#(
    parameter int W = DW
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rx_valid,
    input  logic [W-1:0] rx_byte,
    input  logic         rx_par_err,
    input  logic         rx_frm_err,
    input  logic         data_rd,
    input  logic         err_clr,
    output logic [W-1:0] hold_byte,
    output logic         full,
    output logic         ovr,
    output logic         par_flag,
    output logic         frm_flag
);
    hold_state_t state_q, state_d;
    logic [W-1:0] byte_q;
    logic         par_q, frm_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= HOLD_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HOLD_EMPTY: begin
                if (rx_valid) state_d = HOLD_FULL;
            end
            HOLD_FULL: begin
                if (rx_valid && data_rd) state_d = HOLD_FULL;
                else if (rx_valid)       state_d = HOLD_OVERRUN;
                else if (data_rd)        state_d = HOLD_EMPTY;
            end
            HOLD_OVERRUN: begin
                if (rx_valid && data_rd) state_d = HOLD_FULL;
                else if (rx_valid)       state_d = HOLD_OVERRUN;
                else if (data_rd)        state_d = HOLD_EMPTY;
                else if (err_clr)        state_d = HOLD_FULL;
            end
            default: state_d = HOLD_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_q <= '0;
            par_q  <= 1'b0;
            frm_q  <= 1'b0;
        end else if (rx_valid) begin
            byte_q <= rx_byte;
            par_q  <= rx_par_err;
            frm_q  <= rx_frm_err;
        end else if (data_rd || err_clr) begin
            par_q  <= 1'b0;
            frm_q  <= 1'b0;
        end
    end

    always_comb begin
        hold_byte = byte_q;
        full      = (state_q != HOLD_EMPTY);
        ovr       = (state_q == HOLD_OVERRUN);
        par_flag  = par_q;
        frm_flag  = frm_q;
    end

    AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && full && !data_rd |=> ovr && full); // R3
    AST_READ_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        data_rd && !rx_valid |=> !full && !par_flag && !frm_flag); // R2
    AST_CLR_KEEPS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        err_clr && !rx_valid && !data_rd |=> !ovr && $stable(full) && $stable(hold_byte)); // R4
    AST_COINCIDENT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && data_rd |=> full && !ovr); // R10
endmodule

// File: rtl/acia_rx_irq.sv
module acia_rx_irq
    import acia_rx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rx_valid,
    input  logic rx_irq_en,
    input  logic cmd_wr,
    input  logic cmd_new_irq_en,
    input  logic hold_full,
    input  logic stat_rd,
    output logic pending,
    output logic irq_n
);
    irq_state_t state_q, state_d;
    logic set_evt;

    always_comb begin
        set_evt = (rx_valid && rx_irq_en) || (cmd_wr && cmd_new_irq_en && hold_full);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE: begin
                if (set_evt) state_d = IRQ_ASSERTED;
            end
            IRQ_ASSERTED: begin
                if (stat_rd && !set_evt) state_d = IRQ_IDLE;
            end
            default: state_d = IRQ_IDLE;
        endcase
    end

    always_comb begin
        pending = (state_q == IRQ_ASSERTED);
        irq_n   = (state_q != IRQ_ASSERTED);
    end

    AST_IRQ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd && !set_evt |=> irq_n); // R5
    AST_IRQ_NOT_LOST: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> !irq_n); // R7
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        irq_n && !set_evt |=> irq_n); // R6
endmodule

// File: rtl/acia_rx_cmd.sv
module acia_rx_cmd
    import acia_rx_pkg::*;
#(
    parameter int W = DW
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cmd_wr,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] cmd,
    output logic         rx_irq_en,
    output logic         rts_n,
    output logic         dtr_n
);
    logic [W-1:0] cmd_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cmd_q <= '0;
        else if (cmd_wr) cmd_q <= wr_data;
    end

    always_comb begin
        cmd       = cmd_q;
        rx_irq_en = !cmd_q[CMD_RXIDIS];
        rts_n     = !(cmd_q[CMD_TXC_HI] || cmd_q[CMD_TXC_LO]);
        dtr_n     = !cmd_q[CMD_DTR];
    end

    AST_MODEM_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_wr |=> $stable(rts_n) && $stable(dtr_n)); // R9
endmodule

// File: rtl/acia_rx_regs.sv
module acia_rx_regs
    import acia_rx_pkg::*;
#(
    parameter int W = DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] reg_addr,
    input  logic          rd_stb,
    input  logic          wr_stb,
    input  logic [W-1:0]  wr_data,
    output logic [W-1:0]  rd_data,
    input  logic          rx_valid,
    input  logic [W-1:0]  rx_byte,
    input  logic          rx_par_err,
    input  logic          rx_frm_err,
    input  logic          tx_empty,
    output logic          irq_n,
    output logic          rts_n,
    output logic          dtr_n
);
    logic data_rd, stat_rd, err_clr, cmd_wr;
    logic [W-1:0] hold_byte, cmd, status;
    logic full, ovr, par_flag, frm_flag, pending, rx_irq_en;

    always_comb begin
        data_rd = rd_stb && (reg_addr == ADDR_DATA);
        stat_rd = rd_stb && (reg_addr == ADDR_STATUS);
        err_clr = wr_stb && (reg_addr == ADDR_STATUS);
        cmd_wr  = wr_stb && (reg_addr == ADDR_CMD);
    end

    acia_rx_hold #(.W(W)) u_hold (
        .clk(clk), .rst_n(rst_n),
        .rx_valid(rx_valid), .rx_byte(rx_byte),
        .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err),
        .data_rd(data_rd), .err_clr(err_clr),
        .hold_byte(hold_byte), .full(full), .ovr(ovr),
        .par_flag(par_flag), .frm_flag(frm_flag)
    );

    acia_rx_cmd #(.W(W)) u_cmd (
        .clk(clk), .rst_n(rst_n),
        .cmd_wr(cmd_wr), .wr_data(wr_data),
        .cmd(cmd), .rx_irq_en(rx_irq_en),
        .rts_n(rts_n), .dtr_n(dtr_n)
    );

    acia_rx_irq u_irq (
        .clk(clk), .rst_n(rst_n),
        .rx_valid(rx_valid), .rx_irq_en(rx_irq_en),
        .cmd_wr(cmd_wr), .cmd_new_irq_en(!wr_data[CMD_RXIDIS]),
        .hold_full(full), .stat_rd(stat_rd),
        .pending(pending), .irq_n(irq_n)
    );

    always_comb begin
        status          = '0;
        status[ST_IRQ]  = pending;
        status[ST_TXE]  = tx_empty;
        status[ST_FULL] = full;
        status[ST_OVR]  = ovr;
        status[ST_FRM]  = frm_flag;
        status[ST_PAR]  = par_flag;
        unique case (reg_addr)
            ADDR_DATA:   rd_data = hold_byte;
            ADDR_STATUS: rd_data = status;
            ADDR_CMD:    rd_data = cmd;
            default:     rd_data = '0;
        endcase
    end

    AST_IRQ_MATCHES_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd |-> (rd_data[ST_IRQ] == !irq_n)); // R1
    AST_OVR_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        ovr |-> full); // R3
endmodule

// File: tb/acia_rx_regs_test.sv
`timescale 1ns/1ps
module acia_rx_regs_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] reg_addr = '0;
    logic rd_stb = 1'b0, wr_stb = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic rx_valid = 1'b0;
    logic [7:0] rx_byte = '0;
    logic rx_par_err = 1'b0, rx_frm_err = 1'b0;
    logic tx_empty = 1'b1;
    logic irq_n, rts_n, dtr_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    acia_rx_regs uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .rd_stb(rd_stb),
        .wr_stb(wr_stb), .wr_data(wr_data), .rd_data(rd_data),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_par_err(rx_par_err),
        .rx_frm_err(rx_frm_err), .tx_empty(tx_empty), .irq_n(irq_n),
        .rts_n(rts_n), .dtr_n(dtr_n)
    );

    typedef struct packed {
        logic [1:0] op;   // 0 byte arrives, 1 status read, 2 data read
        logic [7:0] val;
        logic       pe;
        logic       fe;
        logic [7:0] exp;
    } vec_t;

    localparam vec_t VECS [12] = '{
        '{2'd1, 8'h00, 1'b0, 1'b0, 8'h10},
        '{2'd0, 8'h41, 1'b0, 1'b0, 8'h00},
        '{2'd1, 8'h00, 1'b0, 1'b0, 8'h98},
        '{2'd1, 8'h00, 1'b0, 1'b0, 8'h18},
        '{2'd2, 8'h00, 1'b0, 1'b0, 8'h41},
        '{2'd1, 8'h00, 1'b0, 1'b0, 8'h10},
        '{2'd0, 8'h55, 1'b1, 1'b0, 8'h00},
        '{2'd1, 8'h00, 1'b0, 1'b0, 8'h99},
        '{2'd0, 8'h66, 1'b0, 1'b1, 8'h00},
        '{2'd1, 8'h00, 1'b0, 1'b0, 8'h9E},
        '{2'd2, 8'h00, 1'b0, 1'b0, 8'h66},
        '{2'd1, 8'h00, 1'b0, 1'b0, 8'h10}
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // One bus cycle starting just after a falling edge; rv is sampled before the rising edge.
    task automatic step(input logic rd, input logic wr, input logic [1:0] a,
                        input logic [7:0] wd, input logic rxv, input logic [7:0] rb,
                        input logic pe, input logic fe, output logic [7:0] rv);
        reg_addr = a; rd_stb = rd; wr_stb = wr; wr_data = wd;
        rx_valid = rxv; rx_byte = rb; rx_par_err = pe; rx_frm_err = fe;
        #1 rv = rd_data;
        @(posedge clk);
        @(negedge clk);
        rd_stb = 1'b0; wr_stb = 1'b0; rx_valid = 1'b0;
        rx_par_err = 1'b0; rx_frm_err = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [7:0] rv);
        step(1'b1, 1'b0, a, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, rv);
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        logic [7:0] unused_rv;
        step(1'b0, 1'b1, a, d, 1'b0, 8'h00, 1'b0, 1'b0, unused_rv);
    endtask

    task automatic rx_in(input logic [7:0] b, input logic pe, input logic fe);
        logic [7:0] unused_rv;
        step(1'b0, 1'b0, 2'd0, 8'h00, 1'b1, b, pe, fe, unused_rv);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        check("R11 irq_n", {7'd0, irq_n}, 8'h01);
        check("R11 rts_n", {7'd0, rts_n}, 8'h01);
        check("R11 dtr_n", {7'd0, dtr_n}, 8'h01);
        rd_reg(2'd2, v); check("R11 command", v, 8'h00);
        rd_reg(2'd1, v); check("R11 status", v, 8'h10);

        // R9 normal command
        wr_reg(2'd2, 8'h09);
        check("R9 rts_n after 09", {7'd0, rts_n}, 8'h00);
        check("R9 dtr_n after 09", {7'd0, dtr_n}, 8'h00);
        rd_reg(2'd2, v); check("R9 command readback", v, 8'h09);
        rd_reg(2'd3, v); check("R1 unused address", v, 8'h00);

        // R1 R2 R3 R5 R6 table walk
        for (int i = 0; i < 12; i++) begin
            case (VECS[i].op)
                2'd0: begin
                    rx_in(VECS[i].val, VECS[i].pe, VECS[i].fe);
                    if (i == 1) check("R6 irq_n low after arrival", {7'd0, irq_n}, 8'h00);
                end
                2'd1: begin
                    rd_reg(2'd1, v);
                    check("R1 R3 R5 status vector", v, VECS[i].exp);
                    check("R5 irq_n high after status read", {7'd0, irq_n}, 8'h01);
                end
                default: begin
                    rd_reg(2'd0, v);
                    check("R2 data vector", v, VECS[i].exp);
                end
            endcase
        end

        // R1 transmitter-empty input reflected
        tx_empty = 1'b0;
        rd_reg(2'd1, v); check("R1 tx_empty low", v, 8'h00);
        tx_empty = 1'b1;

        // R7 arrival coincides with status read
        step(1'b1, 1'b0, 2'd1, 8'h00, 1'b1, 8'h21, 1'b0, 1'b0, v);
        check("R7 status before arrival", v, 8'h10);
        check("R7 irq_n stays low", {7'd0, irq_n}, 8'h00);
        rd_reg(2'd1, v); check("R7 status after", v, 8'h98);
        rd_reg(2'd0, v); check("R7 data", v, 8'h21);

        // R10 arrival coincides with data read
        rx_in(8'h31, 1'b0, 1'b0);
        rd_reg(2'd1, v); check("R10 status first byte", v, 8'h98);
        step(1'b1, 1'b0, 2'd0, 8'h00, 1'b1, 8'h32, 1'b1, 1'b0, v);
        check("R10 old byte returned", v, 8'h31);
        rd_reg(2'd1, v); check("R10 status no overrun", v, 8'h99);
        rd_reg(2'd0, v); check("R10 new byte held", v, 8'h32);
        rd_reg(2'd1, v); check("R2 status empty", v, 8'h10);

        // R4 error clear through status write
        rx_in(8'h40, 1'b0, 1'b1);
        rx_in(8'h41, 1'b1, 1'b0);
        rd_reg(2'd1, v); check("R3 overrun with parity", v, 8'h9D);
        wr_reg(2'd1, 8'hFF);
        rd_reg(2'd1, v); check("R4 errors cleared full kept", v, 8'h18);
        rd_reg(2'd0, v); check("R4 byte kept", v, 8'h41);
        rd_reg(2'd1, v); check("R4 status after read", v, 8'h10);

        // R6 masked arrival, R8 re-enable with byte held
        wr_reg(2'd2, 8'h0B);
        rx_in(8'h50, 1'b0, 1'b0);
        check("R6 irq_n high when disabled", {7'd0, irq_n}, 8'h01);
        rd_reg(2'd1, v); check("R6 status when disabled", v, 8'h18);
        wr_reg(2'd2, 8'h09);
        check("R8 irq_n low after enable", {7'd0, irq_n}, 8'h00);
        rd_reg(2'd1, v); check("R8 status", v, 8'h98);
        check("R5 irq_n released with byte pending", {7'd0, irq_n}, 8'h01);
        rd_reg(2'd1, v); check("R5 status full no irq", v, 8'h18);
        rd_reg(2'd0, v); check("R8 data", v, 8'h50);

        // R9 flow-control command values
        wr_reg(2'd2, 8'h01);
        check("R9 rts_n after 01", {7'd0, rts_n}, 8'h01);
        check("R9 dtr_n after 01", {7'd0, dtr_n}, 8'h00);
        rd_reg(2'd2, v); check("R9 readback 01", v, 8'h01);
        wr_reg(2'd2, 8'h04);
        check("R9 rts_n after 04", {7'd0, rts_n}, 8'h00);
        check("R9 dtr_n after 04", {7'd0, dtr_n}, 8'h01);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule